// File: doc/BRIEF.md
# Priority Interrupt Controller with Test-Mode Force

This block gathers fifteen interrupt sources, numbered 1 to 15, and presents the most urgent request to a processor as a 4-bit level. Level 0 means that nothing is requesting service. Each source has its own single-cycle pulse input, and a pulse latches into a pending register. A mask register can silence any level from 1 to 14. Level 15 cannot be masked.

A small register port gives access to four registers: pending, mask, clear and force. The force register lets a test program inject requests without the real sources. It can be written only while the test-mode input is high, and it takes part in arbitration only while that input is high. When the processor acknowledges a level, the controller first takes the request away from the force register. It clears the pending bit only when no forced bit accounts for that level.

Top module: `pic_force_ctrl`

## Requirements
- R1: After reset, every register reads as zero, `irq_level_o` is 0 and `rsv_err_o` is 0.
- R2: A pulse on `src_i[k]`, for k from 1 to 15, sets pending bit k at the next clock edge. `src_i[0]` has no effect. The pending register (address 0, read only) always reads bit 0 as zero.
- R3: A write to the mask register (address 1) stores only bits 14:1. Level 15 can never be masked.
- R4: A write to address 1 with any of data bits 31:15 or bit 0 set drives `rsv_err_o` high during that write cycle. Other writes leave it low.
- R5: A write to the clear register (address 2) clears every pending bit in 15:1 that is written as 1. Address 2 reads as zero.
- R6: A source pulse wins over a clear of the same bit in the same cycle, whether the clear comes from a clear-register write or from an acknowledge.
- R7: The force register (address 3) stores bits 15:1 of a write only while `test_mode_i` is high. A write while `test_mode_i` is low leaves it unchanged.
- R8: A level is requested when its pending bit is set, or when its force bit is set and `test_mode_i` is high, and its mask bit is clear.
- R9: `irq_level_o` is the highest requested level, updated in the same cycle as its inputs, and 0 when no level is requested.
- R10: An acknowledge of level L, with L from 1 to 15, clears only force bit L if `test_mode_i` is high and force bit L is set. Otherwise it clears pending bit L. An acknowledge of level 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 pending, 1 mask, 2 clear, 3 force |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| rsv_err_o | output | 1 | Reserved bits set in a mask write |
| test_mode_i | input | 1 | Test mode: enables force writes and forced requests |
| src_i | input | 16 | Source pulses; bit k is level k, bit 0 is unused |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Highest requested level, 0 for none |

## Verification
The bench goes after the cases where two actions meet on one bit in one cycle: a source pulse coinciding with a clear write, and a source pulse coinciding with an acknowledge. A design that let the clear win would silently lose an interrupt. Acknowledge is run with the force bit and the pending bit both set, so a design that cleared both, or cleared the wrong one, shows a changed pending or force readback. Arbitration is checked with level 15 under an all-ones mask, with source bit 0 alone, and with test mode dropped while a forced bit is present. Each of these shows up as a wrong `irq_level_o` if the mask width or the test-mode gating is off. A mask write with reserved bits must raise the error flag while keeping the legal field.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_MASK  = 2'd1,
    REG_CLR   = 2'd2,
    REG_FORCE = 2'd3
  } pic_reg_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              test_i,
  input  logic [2**LVL_W-1:0] src_i,
  input  logic              ack_valid_i,
  input  logic [LVL_W-1:0]  ack_level_i,
  output logic [2**LVL_W-1:0] pend_o,
  output logic [2**LVL_W-1:0] mask_o,
  output logic [2**LVL_W-1:0] force_o,
  output logic              rsv_err_o
);
  localparam int VW = 2**LVL_W;
  localparam logic [VW-1:0] LVL_BITS  = {{(VW-1){1'b1}}, 1'b0};
  localparam logic [VW-1:0] MASK_BITS = LVL_BITS & ~(VW'(1) << (VW-1));
  localparam logic [DW-1:0] MASK_DW   = DW'(MASK_BITS);

  logic [VW-1:0] pend_q, mask_q, force_q;
  logic [VW-1:0] ack_vec, clr_vec, ack_pend, ack_force;
  logic          ack_on_force;

  always_comb begin
    ack_vec = '0;
    if (ack_valid_i && ack_level_i != '0) ack_vec[ack_level_i] = 1'b1;
  end

  assign clr_vec      = (we_i && addr_i == REG_CLR) ? wdata_i[VW-1:0] : '0;
  // forced bit absorbs the acknowledge while test mode is on
  assign ack_on_force = test_i && |(ack_vec & force_q);
  assign ack_force    = ack_on_force ? ack_vec : '0;
  assign ack_pend     = ack_on_force ? '0 : ack_vec;
  assign rsv_err_o    = we_i && addr_i == REG_MASK && |(wdata_i & ~MASK_DW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_vec & ~ack_pend) | src_i) & LVL_BITS;
      if (we_i && addr_i == REG_MASK) mask_q <= wdata_i[VW-1:0] & MASK_BITS;
      if (we_i && addr_i == REG_FORCE && test_i)
        force_q <= wdata_i[VW-1:0] & LVL_BITS & ~ack_force;
      else
        force_q <= force_q & ~ack_force;
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;

  assert_force_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |=> $stable(force_q));

  for (genvar k = 1; k < VW; k++) begin : g_bit_chk
    assert_src_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[k] |=> pend_q[k]);
    assert_clr_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == REG_CLR && wdata_i[k] && !src_i[k]) |=> !pend_q[k]);
    assert_ack_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_valid_i && ack_level_i == LVL_W'(k) && test_i && force_q[k]) |=> !force_q[k]);
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int LVL_W = 4
) (
  input  logic [2**LVL_W-1:0] req_i,
  output logic [LVL_W-1:0]    level_o
);
  localparam int VW = 2**LVL_W;

  // ascending scan: last hit is the highest level
  always_comb begin
    level_o = '0;
    for (int i = 1; i < VW; i++)
      if (req_i[i]) level_o = LVL_W'(i);
  end
endmodule

// File: rtl/pic_force_ctrl.sv
module pic_force_ctrl
  import pic_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int DW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                rsv_err_o,
  input  logic                test_mode_i,
  input  logic [2**LVL_W-1:0] src_i,
  input  logic                ack_valid_i,
  input  logic [LVL_W-1:0]    ack_level_i,
  output logic [LVL_W-1:0]    irq_level_o
);
  localparam int VW = 2**LVL_W;

  logic [VW-1:0] pend, mask, force_v, eff;

  pic_regs #(.LVL_W(LVL_W), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .test_i(test_mode_i), .src_i,
    .ack_valid_i, .ack_level_i,
    .pend_o(pend), .mask_o(mask), .force_o(force_v),
    .rsv_err_o
  );

  assign eff = (pend | (test_mode_i ? force_v : '0)) & ~mask;

  pic_prio #(.LVL_W(LVL_W)) u_prio (
    .req_i(eff),
    .level_o(irq_level_o)
  );

  always_comb begin
    unique case (pic_reg_e'(reg_addr_i))
      REG_PEND:  reg_rdata_o = DW'(pend);
      REG_MASK:  reg_rdata_o = DW'(mask);
      REG_FORCE: reg_rdata_o = DW'(force_v);
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_level_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (eff[irq_level_o] && !mask[irq_level_o]));
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff == '0) |-> (irq_level_o == '0));
  assert_top_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[VW-1] |-> (irq_level_o == LVL_W'(VW-1)));
endmodule

// File: tb/tb_pic_force_ctrl.sv
module tb_pic_force_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        rsv_err, test = 0, ack_v = 0;
  logic [15:0] src = 0;
  logic [3:0]  ack_l = 0, lvl;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_force_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rsv_err_o(rsv_err),
    .test_mode_i(test), .src_i(src), .ack_valid_i(ack_v),
    .ack_level_i(ack_l), .irq_level_o(lvl)
  );

  // {src, mask write, expected level}
  localparam logic [51:0] VEC [7] = '{
    {16'h0002, 32'h0000_0000, 4'd1},
    {16'h8006, 32'h0000_0000, 4'd15},
    {16'h0016, 32'h0000_0006, 4'd4},
    {16'h0400, 32'h0000_0400, 4'd0},
    {16'h7FFE, 32'h0000_7FFE, 4'd0},
    {16'hFFFF, 32'h0000_7FFE, 4'd15},
    {16'h0001, 32'h0000_0000, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = 0;
  endtask

  task automatic ack(input logic [3:0] l);
    @(negedge clk); ack_v = 1; ack_l = l;
    @(negedge clk); ack_v = 0; ack_l = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", {28'd0, lvl}, 0);
    chk("R1 err", {31'd0, rsv_err}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R1 reg", d, 0);
    end
    rst_n = 1;

    for (int i = 0; i < 7; i++) begin
      wr(2'd2, 32'hFFFF);
      wr(2'd1, VEC[i][35:4]);
      pulse(VEC[i][51:36]);
      chk("R9 vector level", {28'd0, lvl}, {28'd0, VEC[i][3:0]});
      rd(2'd0, d); chk("R2 pend readback", d, {16'd0, VEC[i][51:36] & 16'hFFFE});
      rd(2'd1, d); chk("R3 mask readback", d, VEC[i][35:4] & 32'h7FFE);
    end

    // R4 reserved bits on mask write
    @(negedge clk); we = 1; addr = 2'd1; wdata = 32'h0001_8003;
    #1 chk("R4 err high", {31'd0, rsv_err}, 1);
    @(negedge clk); we = 0;
    rd(2'd1, d); chk("R3 mask keeps 14:1", d, 32'h0000_0002);
    @(negedge clk); we = 1; addr = 2'd1; wdata = 32'h0000_0004;
    #1 chk("R4 err low", {31'd0, rsv_err}, 0);
    @(negedge clk); we = 0;
    wr(2'd1, 0);

    // R5 clear register
    wr(2'd2, 32'hFFFF);
    pulse(16'h0028);
    wr(2'd2, 32'h0008);
    rd(2'd0, d); chk("R5 clear selected bit", d, 32'h0020);
    rd(2'd2, d); chk("R5 clear reads zero", d, 0);

    // R6 set beats clear write
    @(negedge clk); src = 16'h0008; we = 1; addr = 2'd2; wdata = 32'h0008;
    @(negedge clk); src = 0; we = 0;
    rd(2'd0, d); chk("R6 set over clear", d, 32'h0028);
    // R6 set beats acknowledge
    @(negedge clk); src = 16'h0008; ack_v = 1; ack_l = 4'd3;
    @(negedge clk); src = 0; ack_v = 0;
    rd(2'd0, d); chk("R6 set over ack", d, 32'h0028);
    // R10 ack level 0 ignored
    ack(4'd0);
    rd(2'd0, d); chk("R10 ack zero ignored", d, 32'h0028);
    wr(2'd2, 32'hFFFF);

    // R7 force write gating
    test = 0; wr(2'd3, 32'h0011);
    rd(2'd3, d); chk("R7 force blocked", d, 0);
    test = 1; wr(2'd3, 32'h0011);
    rd(2'd3, d); chk("R7 force stored", d, 32'h0010);
    // R8 force joins arbitration only in test mode
    chk("R8 forced level", {28'd0, lvl}, 4);
    @(negedge clk); test = 0; #1 chk("R8 force gated off", {28'd0, lvl}, 0);
    test = 1;
    wr(2'd1, 32'h0010);
    chk("R8 forced bit masked", {28'd0, lvl}, 0);
    wr(2'd1, 0);

    // R10 acknowledge steering
    pulse(16'h0010);
    ack(4'd4);
    rd(2'd3, d); chk("R10 force cleared", d, 0);
    rd(2'd0, d); chk("R10 pend kept", d, 32'h0010);
    chk("R9 level from pend", {28'd0, lvl}, 4);
    ack(4'd4);
    rd(2'd0, d); chk("R10 pend cleared", d, 0);
    chk("R9 idle level", {28'd0, lvl}, 0);
    wr(2'd3, 32'h0010);
    pulse(16'h0010);
    test = 0;
    ack(4'd4);
    rd(2'd0, d); chk("R10 test off clears pend", d, 0);
    rd(2'd3, d); chk("R10 test off keeps force", d, 32'h0010);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule